// File: doc/BRIEF.md
# Field-masked status register unit

This block keeps the processor's current status word together with one saved copy for each exception mode that has banked state. A move-to-status operation rewrites any subset of the four byte-wide fields of the chosen target under a 4-bit mask. The new value comes either from a general register or from an immediate constant. A move-from-status operation returns the current word, or the saved word of the mode the core is in now. All operations are conditional. A write that touches the control byte raises a short stall, so that a mode change has settled before the next instruction reads the banked register file.

Two simpler update paths share the register. An ALU flag update replaces the four condition flags. Exception entry saves the current word into the new mode's saved slot, switches mode and masks IRQ. Exception entry has the highest priority, then the move-to-status write, then the flag update.

Top module: `psr_unit`

## Requirements
- R1: After reset the current word reads 0x000000D3 (supervisor, I and F set), every saved word reads 0, and stall_o is low.
- R2: An accepted write changes only the bytes whose mask bit is set, with mask bit 0 for the control byte (bits 7:0), bit 1 for bits 15:8, bit 2 for bits 23:16 and bit 3 for bits 31:24. Any of the 16 mask values is legal, and mask 0 changes nothing.
- R3: use_imm_i high takes the write value from imm_data_i, low from reg_data_i, for every mask and both targets.
- R4: Bits 27:8 of every status word read as zero and ignore written ones, even when their byte is enabled.
- R5: With tgt_saved_i high in FIQ (0x11), IRQ (0x12), supervisor (0x13), abort (0x17) or undefined (0x1B) mode, writes go to and rd_data_o returns that mode's own saved word. With tgt_saved_i low, rd_data_o returns the current word. rd_data_o follows the state and tgt_saved_i without a clock.
- R6: In user (0x10), system (0x1F) or any other mode value, a saved-target read returns the current word, and a saved-target write changes no state and raises no stall.
- R7: With cond_pass_i low, a move-to-status operation changes no state and raises no stall.
- R8: An accepted write whose mask has bit 0 set drives stall_o high for STALL_CYC cycles (default 1), starting in the cycle after the write. An accepted write without bit 0 leaves stall_o low.
- R9: exc_valid_i with a banked exc_mode_i copies the current word into that mode's saved word and sets bits 4:0 to exc_mode_i and bit 7 (I) to 1, keeping every other bit. It overrides a move-to-status operation and a flag update in the same cycle. An exc_mode_i that is not banked is ignored.
- R10: flag_we_i writes flags_i to bits 31:28 (N, Z, C, V) unless an exception entry or an accepted current-word write occurs in the same cycle.
- R11: The control byte holds the mode in bits 4:0, T in bit 5, F in bit 6 and I in bit 7. An immediate 0x1F written under mask 0001 gives system mode with I, F and T clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | A status operation is present |
| op_write_i | input | 1 | 1 = move to status, 0 = move from status |
| cond_pass_i | input | 1 | Condition check passed |
| tgt_saved_i | input | 1 | 1 = saved word of current mode, 0 = current word |
| field_mask_i | input | 4 | Byte write enables, bit 0 control to bit 3 flags |
| use_imm_i | input | 1 | Select the immediate as write source |
| reg_data_i | input | 32 | Register write source |
| imm_data_i | input | 32 | Immediate write source |
| flag_we_i | input | 1 | ALU flag update |
| flags_i | input | 4 | New N, Z, C, V |
| exc_valid_i | input | 1 | Exception entry |
| exc_mode_i | input | 5 | Mode entered on exception |
| rd_data_o | output | 32 | Move-from-status result |
| cpsr_o | output | 32 | Current status word |
| stall_o | output | 1 | Hold the pipeline after a control-byte write |

## Verification
The hardest states to reach are those where several saved words hold different values while the core is in a mode that must not expose any of them. Producing one requires exception entries into two banked modes, a saved-target write in between, and then a move into system or user mode, where saved-target reads and writes must fall back to the current word. The directed sequence builds exactly this chain, including an exception that arrives alongside a competing write. A long random phase then mixes invalid exception modes, arbitrary control bytes and overlapping flag updates against a behavioural model checked every cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W   = 32;
  localparam int FLD_W   = 8;
  localparam int N_FLD   = PSR_W / FLD_W;
  localparam int N_BANK  = 5;
  localparam int BANK_IW = $clog2(N_BANK);
  localparam int BIT_I   = 7;
  localparam int MODE_W  = 5;
  // implemented bits: NZCV and control byte
  localparam logic [PSR_W-1:0] ALLOC_MASK = 32'hF000_00FF;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'h10, MODE_FIQ = 5'h11, MODE_IRQ = 5'h12, MODE_SVC = 5'h13,
    MODE_ABT = 5'h17, MODE_UND = 5'h1B, MODE_SYS = 5'h1F
  } mode_e;

  function automatic logic mode_banked(logic [MODE_W-1:0] m);
    return m inside {MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND};
  endfunction

  function automatic logic [BANK_IW-1:0] mode_slot(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return BANK_IW'(0);
      MODE_IRQ: return BANK_IW'(1);
      MODE_SVC: return BANK_IW'(2);
      MODE_ABT: return BANK_IW'(3);
      MODE_UND: return BANK_IW'(4);
      default:  return BANK_IW'(0);
    endcase
  endfunction
endpackage

// File: rtl/psr_merge.sv
module psr_merge #(
  parameter int W = 32,
  parameter int FW = 8,
  parameter logic [W-1:0] KEEP = '1,
  localparam int NF = W / FW
) (
  input  logic [W-1:0]  old_i,
  input  logic [W-1:0]  data_i,
  input  logic [NF-1:0] mask_i,
  output logic [W-1:0]  merged_o
);
  for (genvar f = 0; f < NF; f++) begin : g_fld
    assign merged_o[f*FW +: FW] =
      (mask_i[f] ? data_i[f*FW +: FW] : old_i[f*FW +: FW]) & KEEP[f*FW +: FW];
  end
endmodule

// File: rtl/psr_bank.sv
module psr_bank #(
  parameter int N = 5,
  parameter int W = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);
  logic [N*W-1:0] flat;

  for (genvar b = 0; b < N; b++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (we_i && wr_idx_i == IW'(b))     q <= wr_data_i;
    end
    assign flat[b*W +: W] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++)
      if (rd_idx_i == IW'(i)) rd_data_o = flat[i*W +: W];
  end
endmodule

// File: rtl/psr_stall.sv
module psr_stall #(
  parameter int CYC = 1,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic stall_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (trig_i)         cnt_q <= CW'(CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign stall_o = (cnt_q != '0);
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int STALL_CYC = 1,
  parameter logic [FLD_W-1:0] RST_CTRL = 8'hD3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        op_valid_i,
  input  logic        op_write_i,
  input  logic        cond_pass_i,
  input  logic        tgt_saved_i,
  input  logic [3:0]  field_mask_i,
  input  logic        use_imm_i,
  input  logic [31:0] reg_data_i,
  input  logic [31:0] imm_data_i,
  input  logic        flag_we_i,
  input  logic [3:0]  flags_i,
  input  logic        exc_valid_i,
  input  logic [4:0]  exc_mode_i,
  output logic [31:0] rd_data_o,
  output logic [31:0] cpsr_o,
  output logic        stall_o
);
  logic [PSR_W-1:0]   cpsr_q, cpsr_d, src, cpsr_mrg, saved_cur, saved_mrg, bank_wdata;
  logic [MODE_W-1:0]  cur_mode;
  logic [BANK_IW-1:0] cur_slot, bank_widx;
  logic cur_banked, exc_take, wr_acc, cpsr_wr, saved_wr, bank_we;

  assign cur_mode   = cpsr_q[MODE_W-1:0];
  assign cur_banked = mode_banked(cur_mode);
  assign cur_slot   = mode_slot(cur_mode);

  assign exc_take = exc_valid_i && mode_banked(exc_mode_i);
  assign wr_acc   = op_valid_i && op_write_i && cond_pass_i && !exc_take;
  assign cpsr_wr  = wr_acc && !tgt_saved_i;
  assign saved_wr = wr_acc && tgt_saved_i && cur_banked;
  assign src      = use_imm_i ? imm_data_i : reg_data_i;

  psr_merge #(.W(PSR_W), .FW(FLD_W), .KEEP(ALLOC_MASK)) u_mrg_cur (
    .old_i(cpsr_q), .data_i(src), .mask_i(field_mask_i), .merged_o(cpsr_mrg)
  );

  psr_merge #(.W(PSR_W), .FW(FLD_W), .KEEP(ALLOC_MASK)) u_mrg_saved (
    .old_i(saved_cur), .data_i(src), .mask_i(field_mask_i), .merged_o(saved_mrg)
  );

  // exception entry owns the bank write port
  assign bank_we    = exc_take || saved_wr;
  assign bank_widx  = exc_take ? mode_slot(exc_mode_i) : cur_slot;
  assign bank_wdata = exc_take ? cpsr_q : saved_mrg;

  psr_bank #(.N(N_BANK), .W(PSR_W)) u_bank (
    .clk_i, .rst_ni,
    .we_i(bank_we), .wr_idx_i(bank_widx), .wr_data_i(bank_wdata),
    .rd_idx_i(cur_slot), .rd_data_o(saved_cur)
  );

  always_comb begin
    cpsr_d = cpsr_q;
    if (exc_take) begin
      cpsr_d[MODE_W-1:0] = exc_mode_i;
      cpsr_d[BIT_I]      = 1'b1;
    end else if (cpsr_wr) begin
      cpsr_d = cpsr_mrg;
    end else if (flag_we_i) begin
      cpsr_d[PSR_W-1 -: 4] = flags_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cpsr_q <= {{(PSR_W-FLD_W){1'b0}}, RST_CTRL};
    else         cpsr_q <= cpsr_d;
  end

  psr_stall #(.CYC(STALL_CYC)) u_stall (
    .clk_i, .rst_ni,
    .trig_i((cpsr_wr || saved_wr) && field_mask_i[0]),
    .stall_o
  );

  assign rd_data_o = (tgt_saved_i && cur_banked) ? saved_cur : cpsr_q;
  assign cpsr_o    = cpsr_q;
endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk
  import psr_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        op_valid_i,
  input logic        op_write_i,
  input logic        cond_pass_i,
  input logic        tgt_saved_i,
  input logic [3:0]  field_mask_i,
  input logic        flag_we_i,
  input logic        exc_valid_i,
  input logic [4:0]  exc_mode_i,
  input logic [31:0] cpsr_o,
  input logic        stall_o
);
  logic wr_req;
  assign wr_req = op_valid_i && op_write_i;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_o[27:8] == '0); // R4

  AST_CTRL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && cond_pass_i && !exc_valid_i && !tgt_saved_i && field_mask_i[0])
    |=> stall_o); // R8

  AST_NO_CTRL_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !(wr_req && cond_pass_i && field_mask_i[0])) |=> !stall_o); // R8

  AST_COND_FAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && !cond_pass_i && !exc_valid_i && !flag_we_i) |=> $stable(cpsr_o)); // R7

  AST_EXC_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && mode_banked(exc_mode_i))
    |=> (cpsr_o[4:0] == $past(exc_mode_i) && cpsr_o[7])); // R9

  AST_FLAGS_ONLY_KEEP_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && cond_pass_i && !exc_valid_i && !tgt_saved_i && field_mask_i == 4'b1000)
    |=> cpsr_o[7:0] == $past(cpsr_o[7:0])); // R2
endmodule

bind psr_unit psr_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_write_i(op_write_i),
  .cond_pass_i(cond_pass_i), .tgt_saved_i(tgt_saved_i), .field_mask_i(field_mask_i),
  .flag_we_i(flag_we_i), .exc_valid_i(exc_valid_i), .exc_mode_i(exc_mode_i),
  .cpsr_o(cpsr_o), .stall_o(stall_o)
);

// File: tb/tb_psr_unit.sv
`timescale 1ns/1ps
module tb_psr_unit;
  logic        clk = 0, rst_ni = 0;
  logic        op_valid_i = 0, op_write_i = 0, cond_pass_i = 0, tgt_saved_i = 0;
  logic [3:0]  field_mask_i = 0;
  logic        use_imm_i = 0;
  logic [31:0] reg_data_i = 0, imm_data_i = 0;
  logic        flag_we_i = 0;
  logic [3:0]  flags_i = 0;
  logic        exc_valid_i = 0;
  logic [4:0]  exc_mode_i = 0;
  logic [31:0] rd_data_o, cpsr_o;
  logic        stall_o;

  always #2 clk = ~clk;

  psr_unit dut (
    .clk_i(clk), .rst_ni, .op_valid_i, .op_write_i, .cond_pass_i, .tgt_saved_i,
    .field_mask_i, .use_imm_i, .reg_data_i, .imm_data_i, .flag_we_i, .flags_i,
    .exc_valid_i, .exc_mode_i, .rd_data_o, .cpsr_o, .stall_o
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  // behavioural reference
  logic [31:0] m_cpsr;
  logic [31:0] m_saved [int];
  int          m_stall;

  function automatic bit banked(logic [4:0] m);
    return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
  endfunction

  function automatic logic [31:0] m_read(bit sv);
    if (sv && banked(m_cpsr[4:0])) return m_saved[int'(m_cpsr[4:0])];
    return m_cpsr;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      finish_run();
    end
  end

  // one operation: called just after a falling edge
  task automatic op(string tag, bit v, bit w, bit c, bit sv, logic [3:0] mk, bit imm,
                    logic [31:0] rd, logic [31:0] id, bit fwe, logic [3:0] fl,
                    bit ev, logic [4:0] em);
    logic [31:0] src, bm, nx;
    bit exc, wr, cw, sw;
    op_valid_i = v; op_write_i = w; cond_pass_i = c; tgt_saved_i = sv;
    field_mask_i = mk; use_imm_i = imm; reg_data_i = rd; imm_data_i = id;
    flag_we_i = fwe; flags_i = fl; exc_valid_i = ev; exc_mode_i = em;
    #0.5;
    chk({tag, " rd_data"}, rd_data_o, m_read(sv));
    exc = ev && banked(em);
    wr  = v && w && c && !exc;
    cw  = wr && !sv;
    sw  = wr && sv && banked(m_cpsr[4:0]);
    src = imm ? id : rd;
    bm  = {{8{mk[3]}}, {8{mk[2]}}, {8{mk[1]}}, {8{mk[0]}}};
    nx  = m_cpsr;
    if (exc) begin
      m_saved[int'(em)] = m_cpsr;
      nx[4:0] = em; nx[7] = 1'b1;
    end else if (cw) begin
      nx = ((m_cpsr & ~bm) | (src & bm)) & 32'hF000_00FF;
    end else begin
      if (sw) m_saved[int'(m_cpsr[4:0])] =
        ((m_saved[int'(m_cpsr[4:0])] & ~bm) | (src & bm)) & 32'hF000_00FF;
      if (fwe) nx[31:28] = fl;
    end
    if ((cw || sw) && mk[0]) m_stall = 1;
    else if (m_stall > 0)    m_stall--;
    m_cpsr = nx;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " cpsr"}, cpsr_o, m_cpsr);
    chk({tag, " stall"}, {31'b0, stall_o}, {31'b0, m_stall != 0});
  endtask

  task automatic msr(string tag, bit sv, logic [3:0] mk, bit imm, logic [31:0] rd, logic [31:0] id);
    op(tag, 1, 1, 1, sv, mk, imm, rd, id, 0, 0, 0, 0);
  endtask

  task automatic idle(string tag, bit sv);
    op(tag, 0, 0, 0, sv, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    m_cpsr = 32'h0000_00D3; m_stall = 0;
    foreach (m_saved[k]) m_saved.delete(k);
    m_saved[32'h11] = 0; m_saved[32'h12] = 0; m_saved[32'h13] = 0;
    m_saved[32'h17] = 0; m_saved[32'h1B] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 reset cpsr", cpsr_o, 32'h0000_00D3);
    chk("R1 reset stall", {31'b0, stall_o}, 32'h0);
    tgt_saved_i = 1; #0.5;
    chk("R1 reset saved", rd_data_o, 32'h0);
    @(negedge clk);

    msr("R2 R4 flags only", 0, 4'b1000, 0, 32'hFFFF_FFFF, 32'h0);
    chk("R4 reserved zero", cpsr_o, 32'hF000_00D3);
    msr("R2 mask zero", 0, 4'b0000, 0, 32'h0000_0000, 32'h0);
    msr("R3 imm all fields", 0, 4'b1111, 1, 32'hFFFF_FFFF, 32'h5A5A_5A10);
    chk("R3 imm chosen", cpsr_o, 32'h5000_0010);
    idle("R8 stall ends", 0);
    msr("R6 user saved write", 1, 4'b1111, 0, 32'hA000_0013, 32'h0);
    idle("R6 user saved read", 1);
    op("R7 cond fail", 1, 1, 0, 0, 4'b1111, 0, 32'h0000_001F, 0, 0, 0, 0, 0);
    msr("R11 sys imm", 0, 4'b0001, 1, 32'h0000_00FF, 32'h0000_001F);
    chk("R11 system mode", cpsr_o, 32'h5000_001F);
    op("R9 exc beats write", 1, 1, 1, 0, 4'b1111, 0, 32'h0, 0, 1, 4'hF, 1, 5'h12);
    chk("R9 irq entry", cpsr_o, 32'h5000_0092);
    idle("R5 irq saved read", 1);
    msr("R5 irq saved write", 1, 4'b1001, 0, 32'h8000_00D3, 32'h0);
    idle("R5 irq saved readback", 1);
    op("R9 fiq entry", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'h11);
    idle("R5 fiq saved", 1);
    op("R9 bad mode ignored", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5'h10);
    op("R10 alu flags", 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'hA, 0, 0);
    op("R10 write blocks flags", 1, 1, 1, 0, 4'b0001, 0, 32'h0000_0012, 0, 1, 4'h3, 0, 0);
    idle("R5 irq saved kept", 1);
    msr("R6 back to sys", 0, 4'b0001, 1, 0, 32'h0000_001F);
    idle("R6 sys saved read", 1);

    for (int i = 0; i < 600; i++) begin
      logic [4:0] em;
      logic [31:0] d;
      case ($urandom_range(0, 7))
        0: em = 5'h11; 1: em = 5'h12; 2: em = 5'h13; 3: em = 5'h17;
        4: em = 5'h1B; 5: em = 5'h10; 6: em = 5'h1F; default: em = 5'($urandom);
      endcase
      d = $urandom;
      if ($urandom_range(0, 3) != 0) d[4:0] = em;
      op("R2 R3 R8 R10 random", bit'($urandom_range(0, 1)), bit'($urandom_range(0, 3) != 0),
         bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)), 4'($urandom),
         bit'($urandom_range(0, 1)), d, $urandom, bit'($urandom_range(0, 1)), 4'($urandom),
         $urandom_range(0, 7) == 0, em);
    end
    finish_run();
  end
endmodule